// File: doc/BRIEF.md
# CPU Exception Priority Arbiter

This block sits beside a processor core's sequencer. It picks the one exception the core should enter next. Reset can come from three places: the external reset pin, a watchdog overflow or an exit from deep standby. An undefined opcode is taken at once. Trace and interrupt requests, and a recorded address error, are taken only when the core reports a boundary, meaning that an instruction or an exception-handling sequence has just completed. Qualified sleep and trap strobes are taken in any cycle of normal execution.

Each request source has its own acceptance condition. Trace is taken only in interrupt mode 2, and never right after a return-from-exception. Interrupts are ignored at a boundary that ends a control-register write, and at the first boundary after a reset exception starts. A sleep instruction counts as an exception only for one combination of the two standby-control bits.

Requests that lose arbitration are not lost. Address errors, sleep strobes and trap strobes are latched until they are taken. Level requests are sampled again at the next boundary.

The block gives the core a one-clock start pulse together with a 3-bit exception code, both registered. It also holds the core in reset while the pin is low.

Top module: `exc_arbiter`

## Requirements
- R1: When several requests are eligible in the same cycle, only the highest is started, in the order reset (code 1), illegal (2), trace (3), address error (4), interrupt (5), sleep (6), trap (7).
- R2: While `rst_pin_n` is low, `core_rst` is 1 and `exc_start` is 0. After the pin rises, `core_rst` stays 1 until the second rising clock edge, falls there, and a reset exception (code 1) is started on the following edge.
- R3: A one-cycle `wdt_ovf` or `dstby_exit` pulse starts a reset exception (code 1) on the next edge. It also discards every latched address error, sleep request and trap request.
- R4: `undef_op` starts an illegal-instruction exception (code 2) on the next edge, even when `boundary` is 0.
- R5: Trace (code 3) starts after a cycle with `boundary`=1 only when `trace_en`=1 and `int_mode`=2.
- R6: Trace is not taken at a boundary where `done_rte`=1.
- R7: An `addr_err` pulse is latched. Its exception (code 4) starts only after a later or the same cycle with `boundary`=1.
- R8: `irq_req` is ignored at a boundary with `done_ctl_wr`=1. It is also ignored at the first boundary after a reset exception starts.
- R9: `sleep_exec` raises a sleep exception (code 6) only when `stby_sel`=0 and `sleep_ie`=1. `trap_exec` raises code 7. Neither needs a boundary.
- R10: Address error, sleep and trap requests that lose arbitration stay pending and are started in later cycles in priority order.
- R11: `exc_start` lasts exactly one clock per accepted exception. `exc_code` is 0 whenever `exc_start` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| dstby_exit | input | 1 | Deep standby exit pulse |
| undef_op | input | 1 | Undefined opcode executed |
| addr_err | input | 1 | Address error pulse |
| irq_req | input | 1 | Interrupt request level |
| sleep_exec | input | 1 | Sleep instruction strobe |
| trap_exec | input | 1 | Trap instruction strobe |
| trace_en | input | 1 | Trace bit |
| int_mode | input | 2 | Interrupt control mode |
| stby_sel | input | 1 | Standby-select control bit |
| sleep_ie | input | 1 | Sleep-interrupt enable bit |
| boundary | input | 1 | Instruction or exception handling completed this cycle |
| done_rte | input | 1 | Completed instruction was a return-from-exception |
| done_ctl_wr | input | 1 | Completed instruction wrote a control register |
| core_rst | output | 1 | Core held in reset |
| exc_start | output | 1 | One-cycle exception start pulse |
| exc_code | output | 3 | Exception type, 0 when idle |

## Verification
Two pairs of functions can fall in the same clock:
- a reset trigger (pin edge or pulse) and the boundary-qualified requests;
- the any-time strobes (illegal, sleep, trap) and a boundary where trace, address error and interrupt are all eligible.

Directed cycles raise every source together. They then step through the following boundaries, which shows that the losers are taken in order afterwards. A seeded random mix drives all inputs at once, and a bench reference model predicts the code for every cycle. Each cycle is judged on `exc_start`, `exc_code` and `core_rst` together.

// File: rtl/exc_arbiter.sv
module exc_arbiter #(
  parameter int         SYNC_STAGES = 2,
  parameter logic [1:0] TRACE_MODE  = 2'd2
) (
  input  logic       clk,
  input  logic       rst_pin_n,
  input  logic       wdt_ovf,
  input  logic       dstby_exit,
  input  logic       undef_op,
  input  logic       addr_err,
  input  logic       irq_req,
  input  logic       sleep_exec,
  input  logic       trap_exec,
  input  logic       trace_en,
  input  logic [1:0] int_mode,
  input  logic       stby_sel,
  input  logic       sleep_ie,
  input  logic       boundary,
  input  logic       done_rte,
  input  logic       done_ctl_wr,
  output logic       core_rst,
  output logic       exc_start,
  output logic [2:0] exc_code
);
  localparam logic [2:0] C_NONE  = 3'd0;
  localparam logic [2:0] C_RESET = 3'd1;
  localparam logic [2:0] C_ILL   = 3'd2;
  localparam logic [2:0] C_TRACE = 3'd3;
  localparam logic [2:0] C_ADDR  = 3'd4;
  localparam logic [2:0] C_IRQ   = 3'd5;
  localparam logic [2:0] C_SLEEP = 3'd6;
  localparam logic [2:0] C_TRAP  = 3'd7;
  localparam int         MSB     = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rel_q;
  logic                   ae_q, sl_q, tr_q, post_rst_q;
  logic [2:0]             nxt;

  always_ff @(posedge clk or negedge rst_pin_n)
    if (!rst_pin_n) begin
      sync_q <= '0;
      rel_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[MSB-1:0], 1'b1};
      rel_q  <= sync_q[MSB];
    end

  assign core_rst = ~sync_q[MSB];

  wire running  = ~core_rst;
  wire pin_rise = sync_q[MSB] & ~rel_q;
  wire req_rst  = pin_rise | (running & (wdt_ovf | dstby_exit));
  wire ae_any   = ae_q | addr_err;
  wire sl_any   = sl_q | (sleep_exec & ~stby_sel & sleep_ie);
  wire tr_any   = tr_q | trap_exec;
  wire req_tr   = boundary & trace_en & (int_mode == TRACE_MODE) & ~done_rte;
  wire req_irq  = boundary & irq_req & ~done_ctl_wr & ~post_rst_q;

  always_comb begin
    nxt = C_NONE;
    if (req_rst)                  nxt = C_RESET;
    else if (running) begin
      if (undef_op)               nxt = C_ILL;
      else if (req_tr)            nxt = C_TRACE;
      else if (boundary & ae_any) nxt = C_ADDR;
      else if (req_irq)           nxt = C_IRQ;
      else if (sl_any)            nxt = C_SLEEP;
      else if (tr_any)            nxt = C_TRAP;
    end
  end

  always_ff @(posedge clk or negedge rst_pin_n)
    if (!rst_pin_n) begin
      ae_q       <= 1'b0;
      sl_q       <= 1'b0;
      tr_q       <= 1'b0;
      post_rst_q <= 1'b0;
      exc_start  <= 1'b0;
      exc_code   <= C_NONE;
    end else begin
      exc_start <= (nxt != C_NONE);
      exc_code  <= nxt;
      if (req_rst) begin
        ae_q       <= 1'b0;
        sl_q       <= 1'b0;
        tr_q       <= 1'b0;
        post_rst_q <= 1'b1;
      end else if (running) begin
        ae_q <= ae_any & (nxt != C_ADDR);
        sl_q <= sl_any & (nxt != C_SLEEP);
        tr_q <= tr_any & (nxt != C_TRAP);
        if (boundary) post_rst_q <= 1'b0;
      end
    end
endmodule

// File: rtl/exc_arbiter_chk.sv
module exc_arbiter_chk (
  input logic       clk,
  input logic       rst_pin_n,
  input logic       wdt_ovf,
  input logic       dstby_exit,
  input logic       undef_op,
  input logic       irq_req,
  input logic       trace_en,
  input logic [1:0] int_mode,
  input logic       boundary,
  input logic       done_rte,
  input logic       done_ctl_wr,
  input logic       core_rst,
  input logic       exc_start,
  input logic [2:0] exc_code
);
  AST_HOLD_WHILE_LOW: assert property (@(posedge clk)
    !rst_pin_n |-> core_rst && !exc_start); // R2

  AST_RESET_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_pin_n)
    $fell(core_rst) |=> exc_start && exc_code == 3'd1); // R2

  AST_ILLEGAL_IMMEDIATE: assert property (@(posedge clk) disable iff (core_rst)
    undef_op && !wdt_ovf && !dstby_exit && !$past(core_rst) |=> exc_code == 3'd2); // R4

  AST_TRACE_QUALIFIED: assert property (@(posedge clk) disable iff (core_rst)
    exc_code == 3'd3 |-> $past(boundary && trace_en && int_mode == 2'd2 && !done_rte)); // R5

  AST_ADDR_AT_BOUNDARY: assert property (@(posedge clk) disable iff (core_rst)
    exc_code == 3'd4 |-> $past(boundary)); // R7

  AST_IRQ_QUALIFIED: assert property (@(posedge clk) disable iff (core_rst)
    exc_code == 3'd5 |-> $past(boundary && irq_req && !done_ctl_wr)); // R8
endmodule

bind exc_arbiter exc_arbiter_chk chk (.*);

// File: tb/tb_exc_arbiter.sv
module tb_exc_arbiter;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_pin_n = 1'b0, wdt_ovf = 1'b0, dstby_exit = 1'b0, undef_op = 1'b0;
  logic addr_err = 1'b0, irq_req = 1'b0, sleep_exec = 1'b0, trap_exec = 1'b0;
  logic trace_en = 1'b0, stby_sel = 1'b0, sleep_ie = 1'b0;
  logic boundary = 1'b0, done_rte = 1'b0, done_ctl_wr = 1'b0;
  logic [1:0] int_mode = 2'd0;
  logic core_rst, exc_start;
  logic [2:0] exc_code;

  exc_arbiter dut (.*);

  int total = 0, bad = 0;
  bit m_ae, m_sl, m_tr, m_after;
  logic [2:0] exp_code;

  task automatic check(string tag, logic [3:0] got, logic [3:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [2:0] predict();
    bit ae = m_ae | addr_err;
    bit sl = m_sl | (sleep_exec & !stby_sel & sleep_ie);
    bit tr = m_tr | trap_exec;
    if (wdt_ovf | dstby_exit)                                  return 3'd1;
    if (undef_op)                                              return 3'd2;
    if (boundary & trace_en & (int_mode == 2'd2) & !done_rte)  return 3'd3;
    if (boundary & ae)                                         return 3'd4;
    if (boundary & irq_req & !done_ctl_wr & !m_after)          return 3'd5;
    if (sl)                                                    return 3'd6;
    if (tr)                                                    return 3'd7;
    return 3'd0;
  endfunction

  task automatic model_step();
    exp_code = predict();
    if (exp_code == 3'd1) begin
      m_ae = 0; m_sl = 0; m_tr = 0; m_after = 1;
    end else begin
      m_ae = (m_ae | addr_err) & (exp_code != 3'd4);
      m_sl = (m_sl | (sleep_exec & !stby_sel & sleep_ie)) & (exp_code != 3'd6);
      m_tr = (m_tr | trap_exec) & (exp_code != 3'd7);
      if (boundary) m_after = 0;
    end
  endtask

  task automatic cyc(string tag);
    model_step();
    @(negedge clk);
    check(tag, {exc_start, exc_code}, {exp_code != 3'd0, exp_code});
    check(tag, {3'd0, core_rst}, 4'd0);
  endtask

  task automatic idle();
    {wdt_ovf, dstby_exit, undef_op, addr_err, irq_req, sleep_exec, trap_exec} = '0;
    {boundary, done_rte, done_ctl_wr} = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    check("R2 held", {3'd0, core_rst}, 4'd1);
    check("R11 idle in reset", {exc_start, exc_code}, 4'd0);
    rst_pin_n = 1'b1;
    @(negedge clk);
    check("R2 sync stage", {3'd0, core_rst}, 4'd1);
    @(negedge clk);
    check("R2 released", {2'd0, exc_start, core_rst}, 4'd0);
    @(negedge clk);
    check("R2 reset exception", {exc_start, exc_code}, 4'b1001);
    m_ae = 0; m_sl = 0; m_tr = 0; m_after = 1;

    boundary = 1; irq_req = 1; cyc("R8 irq after reset");
    idle(); boundary = 1; irq_req = 1; cyc("R8 irq taken");
    idle(); cyc("R11 single pulse");
    boundary = 1; irq_req = 1; done_ctl_wr = 1; cyc("R8 ctl write");
    idle(); undef_op = 1; cyc("R4 illegal no boundary");
    idle(); trace_en = 1; int_mode = 2; boundary = 1; cyc("R5 trace mode 2");
    int_mode = 0; cyc("R5 trace mode 0");
    int_mode = 2; done_rte = 1; cyc("R6 trace after rte");
    idle(); trace_en = 0; int_mode = 0;
    addr_err = 1; cyc("R7 addr latched");
    idle(); cyc("R7 addr waits");
    boundary = 1; cyc("R7 addr taken");
    idle(); stby_sel = 1; sleep_ie = 1; sleep_exec = 1; cyc("R9 sleep standby");
    stby_sel = 0; sleep_ie = 0; cyc("R9 sleep disabled");
    sleep_ie = 1; cyc("R9 sleep taken");
    idle(); trap_exec = 1; cyc("R9 trap taken");
    idle();
    trace_en = 1; int_mode = 2;
    {undef_op, addr_err, irq_req, sleep_exec, trap_exec, boundary} = '1;
    cyc("R1 illegal wins");
    idle(); boundary = 1; irq_req = 1; cyc("R1 trace next");
    done_rte = 1; cyc("R1 addr next");
    cyc("R1 irq next");
    idle(); cyc("R10 sleep pending");
    cyc("R10 trap pending");
    cyc("R10 drained");
    trace_en = 0; int_mode = 0;
    undef_op = 1; wdt_ovf = 1; addr_err = 1; sleep_exec = 1; cyc("R3 watchdog wins");
    idle(); boundary = 1; cyc("R3 pending discarded");
    idle(); dstby_exit = 1; trap_exec = 1; cyc("R3 standby exit");
    idle(); cyc("R3 trap discarded");

    for (int i = 0; i < 3000; i++) begin
      wdt_ovf     = ($urandom % 100) < 2;
      dstby_exit  = ($urandom % 100) < 1;
      undef_op    = ($urandom % 100) < 4;
      addr_err    = ($urandom % 100) < 8;
      irq_req     = ($urandom % 100) < 30;
      sleep_exec  = ($urandom % 100) < 8;
      trap_exec   = ($urandom % 100) < 8;
      trace_en    = $urandom % 2;
      int_mode    = 2'($urandom % 4);
      stby_sel    = $urandom % 2;
      sleep_ie    = $urandom % 2;
      boundary    = ($urandom % 100) < 40;
      done_rte    = ($urandom % 100) < 20;
      done_ctl_wr = ($urandom % 100) < 20;
      cyc("R1 R10 random");
    end
    idle();

    rst_pin_n = 1'b0;
    @(negedge clk);
    check("R2 pin low again", {exc_start, 2'd0, core_rst}, 4'd1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule